// File: doc/BRIEF.md
# Instruction Cache Lock-Fill Controller

This block executes configuration commands for a small set-associative instruction cache. A command carries a 32-bit operand, of which only the low byte is read as a mode byte, and a start address. A separate command flag selects a global invalidate instead. Depending on the mode, the controller turns the cache on or off. For an unknown mode it raises an operand fault. The remaining modes start a load-and-lock run.

A load-and-lock run first flash-clears every valid and lock bit. It then copies contiguous code from memory into whole ways, one word at a time. Block j fills way j. Each word fetched through a valid/ready read port is written into the data array. The same write updates that line's tag and sets its valid and lock bits. The cache arrays and memory sit outside the block, and the controller drives their write and clear strobes.

Top module: `icache_lockfill_ctrl`

## Requirements
- R1: After reset, cache_en_o, busy_o, done_o, fault_o, clr_all_o, wr_en_o and rd_valid_o are all 0.
- R2: An accepted command with cmd_inval_i=0 and operand bit 0 set clears cache_en_o. It pulses done_o the cycle after acceptance and does nothing else.
- R3: Only operand bits [7:0] form the mode. A mode of 0x00 sets cache_en_o and pulses done_o. Bits [31:8] never change the outcome.
- R4: A mode with bit 0 clear that is not 0x00, 0x04 or 0x06 pulses fault_o for one cycle. It gives no done_o, no clear, no write, and no change to cache_en_o.
- R5: An accepted command with cmd_inval_i=1 pulses clr_all_o, which clears all valid and lock bits, and done_o together, for one cycle.
- R6: Mode 0x04 or 0x06 raises busy_o. The first busy cycle asserts clr_all_o with no write.
- R7: The first read address of a run is the command address with bits [3:0] cleared.
- R8: Word k of a run reads address base+4k and writes way k/64. It writes set = addr[7:4], word index = addr[3:2], tag = addr[31:8] and data = the read data. A run writes LOCK_BLOCKS*64 words.
- R9: rd_valid_o with rd_ready_i low holds rd_addr_o for the next cycle. A write happens only in a cycle where rd_valid_o and rd_ready_i are both high.
- R10: busy_o stays high until the cycle the last word is written. In the next cycle busy_o is low and done_o is high for exactly one cycle.
- R11: Commands presented while busy_o is high are ignored. They cause no clear and no done, and leave cache_en_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken when busy_o is low |
| cmd_inval_i | input | 1 | 1 = global invalidate, 0 = configure |
| cmd_op_i | input | 32 | Operand; low byte is the mode |
| cmd_addr_i | input | 32 | Start address for load-and-lock |
| busy_o | output | 1 | Load-and-lock run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle invalid-operand pulse |
| cache_en_o | output | 1 | Cache enable state |
| rd_valid_o | output | 1 | Memory read request |
| rd_ready_i | input | 1 | Memory returns rd_data_i this cycle |
| rd_addr_o | output | 32 | Memory read address |
| rd_data_i | input | 32 | Memory read data |
| clr_all_o | output | 1 | Flash-clear all valid and lock bits |
| wr_en_o | output | 1 | Write data word, tag, valid and lock |
| wr_way_o | output | 1 | Way written |
| wr_set_o | output | 4 | Set written |
| wr_word_o | output | 2 | Word index within line |
| wr_tag_o | output | 24 | Tag written |
| wr_data_o | output | 32 | Data word written |

## Verification
The main stimulus is a stream of random operands, biased toward low bytes of zero, odd and arbitrary even values, with random upper bytes. This stream separates the enable, disable and fault paths and shows that bits above the mode byte have no effect. Load-and-lock runs use an unaligned start address and a mode carrying upper garbage bits, under a random memory ready pattern. The unaligned address exercises alignment and set wrap-around. The random ready pattern separates address holding from advancing. A global invalidate injected mid-run shows whether commands during busy are ignored. After each run, a model of the cache arrays is compared line by line against the expected tags and data.

// File: rtl/icl_pkg.sv
package icl_pkg;
  typedef enum logic [1:0] {
    OP_DISABLE,
    OP_ENABLE,
    OP_LOCK,
    OP_BAD
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_FILL
  } ctrl_state_e;
endpackage

// File: rtl/icl_mode_decode.sv
module icl_mode_decode
  import icl_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0] op_i,
  output op_kind_e        kind_o
);
  localparam logic [OP_W-1:0] MODE_MASK = OP_W'(8'hff);

  logic [OP_W-1:0] mode;
  assign mode = op_i & MODE_MASK;

  always_comb begin
    if (mode[0])                                   kind_o = OP_DISABLE;
    else if (mode == '0)                           kind_o = OP_ENABLE;
    else if (mode == OP_W'(4) || mode == OP_W'(6)) kind_o = OP_LOCK;
    else                                           kind_o = OP_BAD;
  end
endmodule

// File: rtl/icl_fill_seq.sv
module icl_fill_seq #(
  parameter int ADDR_W          = 32,
  parameter int WORD_BYTES      = 4,
  parameter int LINE_BYTES      = 16,
  parameter int WORDS_PER_BLOCK = 64,
  parameter int WAY_W           = 1,
  parameter int LOCK_BLOCKS     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WAY_W-1:0]  way_o,
  output logic              last_o
);
  localparam int WCNT_W = $clog2(WORDS_PER_BLOCK);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LINE_BYTES - 1);
  localparam logic [WCNT_W-1:0] LAST_WORD  = WCNT_W'(WORDS_PER_BLOCK - 1);
  localparam logic [WAY_W-1:0]  LAST_BLK   = WAY_W'(LOCK_BLOCKS - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [WCNT_W-1:0] wcnt_q;
  logic [WAY_W-1:0]  blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wcnt_q <= '0;
      blk_q  <= '0;
    end else if (start_i) begin
      addr_q <= base_i & ALIGN_MASK;
      wcnt_q <= '0;
      blk_q  <= '0;
    end else if (step_i) begin
      addr_q <= addr_q + ADDR_W'(WORD_BYTES);
      if (wcnt_q == LAST_WORD) begin
        wcnt_q <= '0;
        blk_q  <= blk_q + 1'b1;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  assign addr_o = addr_q;
  assign way_o  = blk_q;
  assign last_o = (wcnt_q == LAST_WORD) && (blk_q == LAST_BLK);
endmodule

// File: rtl/icache_lockfill_ctrl.sv
module icache_lockfill_ctrl
  import icl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_WAYS    = 2,
  parameter int NUM_SETS    = 16,
  parameter int LINE_BYTES  = 16,
  parameter int LOCK_BLOCKS = 2,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int BOFF_W     = $clog2(WORD_BYTES),
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int SET_W      = $clog2(NUM_SETS),
  localparam int WIDX_W     = OFF_W - BOFF_W,
  localparam int TAG_W      = ADDR_W - SET_W - OFF_W,
  localparam int WAY_W      = $clog2(NUM_WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_inval_i,
  input  logic [DATA_W-1:0] cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              cache_en_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              clr_all_o,
  output logic              wr_en_o,
  output logic [WAY_W-1:0]  wr_way_o,
  output logic [SET_W-1:0]  wr_set_o,
  output logic [WIDX_W-1:0] wr_word_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int WORDS_PER_BLOCK = NUM_SETS * LINE_BYTES / WORD_BYTES;

  if (LOCK_BLOCKS > NUM_WAYS || LOCK_BLOCKS < 1) begin : g_bad_cfg
    $error("LOCK_BLOCKS must be between 1 and NUM_WAYS");
  end

  ctrl_state_e state_q;
  logic        cache_en_q, done_q, fault_q, inval_q;
  op_kind_e    kind;
  logic        accept, seq_start, seq_last;
  logic [ADDR_W-1:0] seq_addr;

  icl_mode_decode #(.OP_W(DATA_W)) u_dec (
    .op_i   (cmd_op_i),
    .kind_o (kind)
  );

  assign accept    = cmd_valid_i && (state_q == ST_IDLE);
  assign seq_start = accept && !cmd_inval_i && (kind == OP_LOCK);

  icl_fill_seq #(
    .ADDR_W          (ADDR_W),
    .WORD_BYTES      (WORD_BYTES),
    .LINE_BYTES      (LINE_BYTES),
    .WORDS_PER_BLOCK (WORDS_PER_BLOCK),
    .WAY_W           (WAY_W),
    .LOCK_BLOCKS     (LOCK_BLOCKS)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (seq_start),
    .base_i  (cmd_addr_i),
    .step_i  (wr_en_o),
    .addr_o  (seq_addr),
    .way_o   (wr_way_o),
    .last_o  (seq_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cache_en_q <= 1'b0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      inval_q    <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      inval_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (cmd_inval_i) begin
              inval_q <= 1'b1;
              done_q  <= 1'b1;
            end else begin
              unique case (kind)
                OP_DISABLE: begin cache_en_q <= 1'b0; done_q <= 1'b1; end
                OP_ENABLE:  begin cache_en_q <= 1'b1; done_q <= 1'b1; end
                OP_LOCK:    state_q <= ST_CLEAR;
                default:    fault_q <= 1'b1;
              endcase
            end
          end
        end
        ST_CLEAR: state_q <= ST_FILL;
        ST_FILL: begin
          if (rd_ready_i && seq_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign cache_en_o = cache_en_q;
  assign clr_all_o  = (state_q == ST_CLEAR) || inval_q;

  // fetch and write in the same handshake cycle
  assign rd_valid_o = (state_q == ST_FILL);
  assign rd_addr_o  = seq_addr;
  assign wr_en_o    = rd_valid_o && rd_ready_i;
  assign wr_set_o   = seq_addr[OFF_W +: SET_W];
  assign wr_word_o  = seq_addr[BOFF_W +: WIDX_W];
  assign wr_tag_o   = seq_addr[ADDR_W-1 -: TAG_W];
  assign wr_data_o  = rd_data_i;
endmodule

// File: rtl/icl_checker.sv
module icl_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              fault_o,
  input logic              cache_en_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              clr_all_o,
  input logic              wr_en_o
);
  // R4
  fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !done_o && !busy_o && !clr_all_o);

  // R6
  clear_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> clr_all_o && !wr_en_o);

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

  // R9
  write_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o && rd_valid_o);

  // R10
  done_on_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R11
  en_frozen_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cache_en_o));
endmodule

bind icache_lockfill_ctrl icl_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fault_o    (fault_o),
  .cache_en_o (cache_en_o),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .rd_addr_o  (rd_addr_o),
  .clr_all_o  (clr_all_o),
  .wr_en_o    (wr_en_o)
);

// File: tb/icache_lockfill_ctrl_tb_top.sv
`timescale 1ns/1ps
module icache_lockfill_ctrl_tb_top;
  localparam int NS = 16, NW = 2, WPL = 4, WPB = 64, NBLK = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_inval = 1'b0;
  logic [31:0] cmd_op = '0, cmd_addr = '0;
  logic busy, done, fault, cache_en, rd_valid, rd_ready = 1'b0;
  logic [31:0] rd_addr, rd_data;
  logic clr_all, wr_en;
  logic [0:0]  wr_way;
  logic [3:0]  wr_set;
  logic [1:0]  wr_word;
  logic [23:0] wr_tag;
  logic [31:0] wr_data;

  int errors = 0, checks = 0;

  logic        mv [NS][NW];
  logic        ml [NS][NW];
  logic [23:0] mt [NS][NW];
  logic [31:0] md [NS][NW][WPL];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  assign rd_data = mem_fn(rd_addr);

  icache_lockfill_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_inval_i(cmd_inval),
    .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
    .busy_o(busy), .done_o(done), .fault_o(fault), .cache_en_o(cache_en),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .clr_all_o(clr_all), .wr_en_o(wr_en), .wr_way_o(wr_way),
    .wr_set_o(wr_set), .wr_word_o(wr_word), .wr_tag_o(wr_tag), .wr_data_o(wr_data)
  );

  // cache array model
  always @(negedge clk) begin
    if (clr_all)
      for (int s = 0; s < NS; s++)
        for (int w = 0; w < NW; w++) begin mv[s][w] = 1'b0; ml[s][w] = 1'b0; end
    if (wr_en) begin
      md[wr_set][wr_way][wr_word] = wr_data;
      mt[wr_set][wr_way] = wr_tag;
      mv[wr_set][wr_way] = 1'b1;
      ml[wr_set][wr_way] = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // 0 disable, 1 enable, 2 lock, 3 fault
  function automatic int exp_kind(input logic [31:0] op);
    logic [7:0] m = op[7:0];
    if (m[0]) return 0;
    if (m == 8'h00) return 1;
    if (m == 8'h04 || m == 8'h06) return 2;
    return 3;
  endfunction

  task automatic issue(input logic inval, input logic [31:0] op, input logic [31:0] addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_inval = inval; cmd_op = op; cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic single_cmd(input logic inval, input logic [31:0] op);
    logic en_before = cache_en;
    int k = exp_kind(op);
    issue(inval, op, $urandom);
    if (inval) begin
      chk("R5 clr_all", {63'd0, clr_all}, 64'd1);
      chk("R5 done", {63'd0, done}, 64'd1);
      chk("R5 enable kept", {63'd0, cache_en}, {63'd0, en_before});
    end else if (k == 0) begin
      chk("R2 enable off", {63'd0, cache_en}, 64'd0);
      chk("R2 done/no clear", {62'd0, done, clr_all}, 64'd2);
    end else if (k == 1) begin
      chk("R3 enable on", {63'd0, cache_en}, 64'd1);
      chk("R3 done/no clear", {62'd0, done, clr_all}, 64'd2);
    end else begin
      chk("R4 fault pulse", {60'd0, fault, done, clr_all, busy}, 64'h8);
      chk("R4 enable kept", {63'd0, cache_en}, {63'd0, en_before});
    end
  endtask

  task automatic run_lock(input logic [31:0] op, input logic [31:0] addr, input bit poke);
    logic [31:0] base = addr & ~32'hF;
    logic en_before = cache_en;
    int n = 0, cyc = 0, bad_addr = 0, bad_wr = 0, stray = 0;
    issue(1'b0, op, addr);
    chk("R6 first busy cycle clears", {61'd0, busy, clr_all, wr_en}, 64'h6);
    while (busy && cyc < 5000) begin
      if (poke && cyc == 5) begin cmd_valid = 1'b1; cmd_inval = 1'b1; cmd_op = 32'h1; end
      if (poke && cyc == 7) cmd_valid = 1'b0;
      rd_ready = ($urandom % 3) != 0;
      #1;
      if (cyc > 0 && clr_all) stray++;
      if (rd_valid && rd_addr !== base + 32'(n * 4)) begin
        bad_addr++;
        if (bad_addr == 1) chk("R7/R8/R9 read address", 64'(rd_addr), 64'(base + 32'(n * 4)));
      end
      if (wr_en) begin
        logic [31:0] a = base + 32'(n * 4);
        if ({wr_way, wr_set, wr_word, wr_tag, wr_data} !==
            {1'(n / WPB), a[7:4], a[3:2], a[31:8], mem_fn(a)}) begin
          bad_wr++;
          if (bad_wr == 1) chk("R8 write fields", 64'({wr_way, wr_set, wr_word}),
                               64'({1'(n / WPB), a[7:4], a[3:2]}));
        end
        n++;
      end
      @(negedge clk);
      cyc++;
    end
    rd_ready = 1'b0;
    chk("R7/R8 address stream errors", 64'(bad_addr), 64'd0);
    chk("R8 word count", 64'(n), 64'(NBLK * WPB));
    chk("R10 busy low, done high", {62'd0, busy, done}, 64'd1);
    chk("R11 no clear during run", 64'(stray), 64'd0);
    chk("R11 enable unchanged", {63'd0, cache_en}, {63'd0, en_before});
    @(negedge clk);
    chk("R10 done one cycle", {63'd0, done}, 64'd0);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NBLK; w++) begin
        logic [31:0] la = base + 32'(w * NS * 16) + 32'(((s - int'(base[7:4])) & 15) * 16);
        logic ok = mv[s][w] && ml[s][w] && (mt[s][w] == la[31:8]);
        for (int j = 0; j < WPL; j++) ok &= (md[s][w][j] == mem_fn(la + 32'(j * 4)));
        chk("R8 locked line content", {63'd0, ok}, 64'd1);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1CAC4E);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin mv[s][w] = 1'b1; ml[s][w] = 1'b1; end
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {57'd0, cache_en, busy, done, fault, clr_all, wr_en, rd_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {57'd0, cache_en, busy, done, fault, clr_all, wr_en, rd_valid}, 64'd0);

    // directed corners
    single_cmd(1'b0, 32'hFFFF_FF00); // R3 upper bits ignored -> enable
    @(negedge clk);
    chk("R3 done pulse ends", {63'd0, done}, 64'd0);
    single_cmd(1'b0, 32'h0000_0002); // R4
    @(negedge clk);
    chk("R4 fault pulse ends", {63'd0, fault}, 64'd0);
    single_cmd(1'b0, 32'h0000_0101); // R2 via low byte
    single_cmd(1'b0, 32'h0000_0000);
    single_cmd(1'b0, 32'h0000_0007); // R2 odd value with lock-like bits

    run_lock(32'h0000_0004, 32'h1234_567B, 1'b1);
    single_cmd(1'b1, 32'h0);
    @(negedge clk);
    begin
      int any = 0;
      for (int s = 0; s < NS; s++)
        for (int w = 0; w < NW; w++) any += mv[s][w] + ml[s][w];
      chk("R5 all valid/lock cleared", 64'(any), 64'd0);
    end

    // random single commands
    for (int i = 0; i < 80; i++) begin
      logic [31:0] op = $urandom;
      int r = $urandom % 4;
      if (r == 0) op[7:0] = 8'h00;
      else if (r == 1) op[0] = 1'b1;
      if (op[7:0] == 8'h04 || op[7:0] == 8'h06) op[7:0] = 8'h0A;
      single_cmd(($urandom % 5) == 0, op);
    end

    run_lock(32'hABCD_0006, {$urandom} | 32'h9, 1'b0);
    report();
  end
endmodule